// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

A synthesizable model of a single-port synchronous SRAM. The address and control inputs of an access are taken on one rising clock edge, and the data for that access moves on the following edge. Write data is therefore registered one cycle after its command. Read data flows straight out of the array, with no output register, during the cycle after its command. Because both directions share this one-cycle offset, reads and writes can alternate on every clock with no idle cycle on the bus.

A loaded address can be continued as a four-beat burst, in linear or interleaved order. Three chip selects of mixed polarity allow depth expansion. An active-low clock enable and a sleep input both freeze the whole pipeline. The bidirectional data bus appears as separate `wdata` and `rdata` ports plus a drive-enable output `rdata_oe`, which the surrounding logic uses to control the pad.

Top module: `zt_sram`

## Requirements
- R1: An edge with `cke_n`=0, `sleep`=0, `adv_ld`=0, `rw`=1 and all chip selects true (`cs1_n`=0, `cs2`=1, `cs3_n`=0) loads a read. During the next cycle `rdata` shows the word at the loaded address, and `rdata_oe` is 1 if `oe_n` is 0.
- R2: A load with `rw`=0 issues a write. On the next active edge, `wdata` is stored into the word. Byte i is bits [9i+8:9i], and it is written only where `bwe_n[i]`=0.
- R3: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued directly after a write to the same address returns the newly written data.
- R4: An edge with `cke_n`=1 changes no internal state and stores nothing. Outputs keep their values as if that edge had not occurred.
- R5: A load edge (`adv_ld`=0) with any chip select false starts no access and ends any burst in progress. A write already pending still lands, and `rdata_oe` is 0 during the following cycle.
- R6: `rdata_oe` is 0 during the cycle after a write is issued, whether by a load or by a burst continuation.
- R7: An edge with `adv_ld`=1 while a burst is active ignores `addr` and `rw`. It accesses the next burst address, keeping the read or write type of the burst. Beat k uses the upper address bits of the loaded address. Its low two bits are (base+k) mod 4 when `burst_ilv`=0, and base XOR k when `burst_ilv`=1. The counter wraps after four beats.
- R8: `bwe_n` is sampled again on every write burst continuation and applies to that beat's data. `bwe_n` is ignored for reads.
- R9: While `oe_n`=1, `rdata_oe` is 0 at once, whatever the pipeline state.
- R10: An edge with `sleep`=1 changes no state, and memory contents are kept.
- R11: After reset `rdata_oe` is 0 and no burst is active, so a continuation edge starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| cke_n | input | 1 | Active-low clock enable |
| sleep | input | 1 | High freezes all state |
| adv_ld | input | 1 | 0 loads a new address, 1 continues the burst |
| rw | input | 1 | 1 read, 0 write (load cycles only) |
| addr | input | ADDR_W | Word address |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| bwe_n | input | NBYTES | Per-byte write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| wdata | input | NBYTES*BYTE_W | Write data for the pending write |
| rdata | output | NBYTES*BYTE_W | Flow-through read data |
| rdata_oe | output | 1 | Data bus drive enable |

## Verification
The assertions take `burst_ilv` as static while a burst runs and treat `oe_n` as a level that may change at any time. They also assume `cke_n`, `sleep` and the chip selects are valid at every clock edge. The stimulus drives every input shortly after the falling edge, so all inputs are settled at the rising edge. It changes `burst_ilv` only between two separate random phases, each of which opens with a fresh load. Random addresses stay inside a window that the bench fills first, so that every read has a known expected word.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 10,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              sleep,
  input  logic              adv_ld,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic [NBYTES-1:0] bwe_n,
  input  logic              oe_n,
  input  logic              burst_ilv,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              pend_vld, pend_wr;
  logic [ADDR_W-1:0] pend_addr;
  logic [NBYTES-1:0] pend_bwe;
  logic              b_act, b_wr;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt;

  logic       tick, sel;
  logic [1:0] nxt_cnt, nxt_low;
  logic [ADDR_W-1:0] cont_addr;

  assign tick      = !cke_n && !sleep;
  assign sel       = !cs1_n && cs2 && !cs3_n;
  assign nxt_cnt   = b_cnt + 2'd1;
  assign nxt_low   = burst_ilv ? (b_base[1:0] ^ nxt_cnt) : (b_base[1:0] + nxt_cnt);
  assign cont_addr = {b_base[ADDR_W-1:2], nxt_low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_wr   <= 1'b0;
      pend_addr <= '0;
      pend_bwe  <= '1;
      b_act     <= 1'b0;
      b_wr      <= 1'b0;
      b_base    <= '0;
      b_cnt     <= '0;
    end else if (tick) begin
      if (!adv_ld) begin
        if (sel) begin
          pend_vld  <= 1'b1;
          pend_wr   <= !rw;
          pend_addr <= addr;
          pend_bwe  <= rw ? '1 : bwe_n;
          b_act     <= 1'b1;
          b_wr      <= !rw;
          b_base    <= addr;
          b_cnt     <= '0;
        end else begin
          pend_vld <= 1'b0;
          b_act    <= 1'b0;
        end
      end else if (b_act) begin
        pend_vld  <= 1'b1;
        pend_wr   <= b_wr;
        pend_addr <= cont_addr;
        pend_bwe  <= b_wr ? bwe_n : '1;
        b_cnt     <= nxt_cnt;
      end else begin
        pend_vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tick && pend_vld && pend_wr) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (!pend_bwe[i]) mem[pend_addr][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rdata    = mem[pend_addr];
  assign rdata_oe = pend_vld && !pend_wr && !oe_n;
endmodule

module zt_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_n,
  input logic              sleep,
  input logic              adv_ld,
  input logic              rw,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              oe_n,
  input logic              rdata_oe,
  input logic              pend_vld,
  input logic              pend_wr,
  input logic [ADDR_W-1:0] pend_addr,
  input logic              b_act,
  input logic [ADDR_W-1:0] b_base
);
  logic go, on;
  assign go = !cke_n && !sleep;
  assign on = !cs1_n && cs2 && !cs3_n;

  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !adv_ld && on && rw) |=> (oe_n || rdata_oe));
  a_r4_cke_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(pend_vld) && $stable(pend_wr) && $stable(pend_addr) && $stable(b_act)));
  a_r5_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !adv_ld && !on) |=> !rdata_oe);
  a_r6_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !adv_ld && on && !rw) |=> !rdata_oe);
  a_r7_burst_page: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv_ld && b_act) |=> (pend_vld && pend_addr[ADDR_W-1:2] == $past(b_base[ADDR_W-1:2])));
  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe);
  a_r10_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(pend_vld) && $stable(pend_wr) && $stable(pend_addr) && $stable(b_act)));
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |-> !rdata_oe);
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sleep(sleep), .adv_ld(adv_ld), .rw(rw),
  .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .oe_n(oe_n), .rdata_oe(rdata_oe),
  .pend_vld(pend_vld), .pend_wr(pend_wr), .pend_addr(pend_addr),
  .b_act(b_act), .b_base(b_base)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int NB = 4;
  localparam int DW = 36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke_n = 1'b0, sleep = 1'b0, adv_ld = 1'b1, rw = 1'b1;
  logic [AW-1:0] addr = '0;
  logic cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic [NB-1:0] bwe_n = '1;
  logic oe_n = 1'b0, burst_ilv = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [DW-1:0] mm [1 << AW];
  bit mk [1 << AW];
  logic e_vld = 0, e_wr = 0, b_act = 0, b_wr = 0;
  logic [AW-1:0] e_addr = '0, b_base = '0;
  logic [NB-1:0] e_bwe = '1;
  logic [1:0] b_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zt_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sleep(sleep), .adv_ld(adv_ld), .rw(rw),
    .addr(addr), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .bwe_n(bwe_n), .oe_n(oe_n),
    .burst_ilv(burst_ilv), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] base, logic [1:0] k, logic ilv);
    logic [1:0] lo;
    lo = ilv ? (base[1:0] ^ k) : (base[1:0] + k);
    return {base[AW-1:2], lo};
  endfunction

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    logic eo;
    eo = e_vld && !e_wr && !oe_n;
    check(rdata_oe === eo, {tag, " oe"}, DW'(rdata_oe), DW'(eo));
    if (eo && mk[e_addr]) check(rdata === mm[e_addr], {tag, " data"}, rdata, mm[e_addr]);
  endtask

  task automatic model_edge;
    logic sel;
    if (cke_n || sleep) return;
    if (e_vld && e_wr) begin
      for (int i = 0; i < NB; i++)
        if (!e_bwe[i]) mm[e_addr][i*9 +: 9] = wdata[i*9 +: 9];
      if (e_bwe == '0) mk[e_addr] = 1;
    end
    sel = !cs1_n && cs2 && !cs3_n;
    if (!adv_ld) begin
      if (sel) begin
        e_vld = 1; e_wr = !rw; e_addr = addr; e_bwe = rw ? '1 : bwe_n;
        b_act = 1; b_wr = !rw; b_base = addr; b_cnt = 0;
      end else begin
        e_vld = 0; b_act = 0;
      end
    end else if (b_act) begin
      b_cnt = b_cnt + 2'd1;
      e_vld = 1; e_wr = b_wr; e_addr = burst_addr(b_base, b_cnt, burst_ilv);
      e_bwe = b_wr ? bwe_n : '1;
    end else e_vld = 0;
  endtask

  // cs = {cs3_n, cs2, cs1_n}; 3'b010 selects
  task automatic cyc(input logic ck, input logic sl, input logic al, input logic r,
                     input logic [AW-1:0] a, input logic [2:0] cs, input logic [NB-1:0] bw,
                     input logic [DW-1:0] wd, input string tag);
    cke_n = ck; sleep = sl; adv_ld = al; rw = r; addr = a;
    {cs3_n, cs2, cs1_n} = cs; bwe_n = bw; wdata = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return {26'($urandom), a};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [DW-1:0] d, dn;
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << AW); i++) mk[i] = 0;
    repeat (3) @(negedge clk);
    check(rdata_oe === 1'b0, "R11 reset", DW'(rdata_oe), '0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 0, 1, 1, 10'd3, 3'b010, '1, '0, "R11 continue after reset");

    // preload 0..63 and 1020..1023 with back-to-back writes
    d = '0;
    for (int k = 0; k < 68; k++) begin
      logic [AW-1:0] a;
      a = (k < 64) ? AW'(k) : AW'(956 + k);
      dn = pat(a);
      cyc(0, 0, 0, 0, a, 3'b010, 4'b0000, d, "R3 preload");
      d = dn;
    end
    cyc(0, 0, 0, 1, 10'd0, 3'b000, '1, d, "R5 deselect after write");

    cyc(0, 0, 0, 1, 10'd1023, 3'b010, '1, '0, "R1 read top");
    cyc(0, 0, 0, 1, 10'd0, 3'b010, '1, '0, "R1 read zero");

    // byte masks
    cyc(0, 0, 0, 0, 10'd5, 3'b010, 4'b1010, '0, "R6 write issue");
    cyc(0, 0, 0, 1, 10'd5, 3'b010, '1, 36'h123456789, "R2 R3 read after masked write");
    cyc(0, 0, 0, 0, 10'd7, 3'b010, 4'b0000, '0, "R3 write");
    cyc(0, 0, 0, 1, 10'd7, 3'b010, 4'b0000, 36'hABCDEF012, "R3 read same");
    cyc(0, 0, 0, 0, 10'd8, 3'b010, 4'b0000, '0, "R3 write after read");
    cyc(0, 0, 0, 1, 10'd8, 3'b010, '1, 36'h0F0F0F0F0, "R3 read");
    check(rdata === 36'h0F0F0F0F0, "R3 turnaround value", rdata, 36'h0F0F0F0F0);

    // clock enable and sleep freeze
    cyc(0, 0, 0, 1, 10'd3, 3'b010, '1, '0, "R1 read");
    cyc(1, 0, 0, 0, 10'd9, 3'b010, 4'b0000, '1, "R4 cke freeze");
    cyc(0, 1, 0, 0, 10'd9, 3'b010, 4'b0000, '1, "R10 sleep freeze");
    cyc(0, 0, 0, 1, 10'd9, 3'b010, '1, '0, "R4 R10 read unchanged");

    // deselect while a write is pending, each select
    cyc(0, 0, 0, 0, 10'd11, 3'b010, 4'b0000, '0, "R6 write");
    cyc(0, 0, 0, 1, 10'd11, 3'b000, '1, 36'h5A5A5A5A5, "R5 cs2 low");
    cyc(0, 0, 0, 1, 10'd11, 3'b011, '1, '0, "R5 cs1 high");
    cyc(0, 0, 0, 1, 10'd11, 3'b110, '1, '0, "R5 cs3 high");
    cyc(0, 0, 1, 1, 10'd11, 3'b010, '1, '0, "R5 burst ended");
    cyc(0, 0, 0, 1, 10'd11, 3'b010, '1, '0, "R5 pending write landed");

    // bursts, linear then interleaved, six beats to cover wrap
    for (int m = 0; m < 2; m++) begin
      burst_ilv = m[0];
      cyc(0, 0, 0, 1, 10'd21, 3'b010, '1, '0, "R7 burst load");
      for (int b = 0; b < 5; b++) cyc(0, 0, 1, 0, 10'd60, 3'b000, 4'b0000, '0, "R7 burst beat");
    end
    // write burst with per-beat masks, then read back
    burst_ilv = 1'b0;
    cyc(0, 0, 0, 0, 10'd30, 3'b010, 4'b0000, '0, "R6 burst write load");
    cyc(0, 0, 1, 1, 10'd2, 3'b010, 4'b1110, pat(10'd30), "R8 beat1");
    cyc(0, 0, 1, 1, 10'd2, 3'b010, 4'b0111, pat(10'd31), "R8 beat2");
    cyc(0, 0, 1, 1, 10'd2, 3'b010, 4'b1111, pat(10'd28), "R8 beat3");
    cyc(0, 0, 0, 1, 10'd28, 3'b010, 4'b0000, pat(10'd29), "R8 read load");
    for (int b = 0; b < 3; b++) cyc(0, 0, 1, 0, 10'd0, 3'b010, 4'b0000, '0, "R8 read beat");

    // asynchronous output enable
    cyc(0, 0, 0, 1, 10'd40, 3'b010, '1, '0, "R9 read");
    oe_n = 1'b1; #1;
    check(rdata_oe === 1'b0, "R9 oe high", DW'(rdata_oe), '0);
    oe_n = 1'b0; #1;
    check(rdata_oe === 1'b1, "R9 oe low", DW'(rdata_oe), DW'(1));

    // random phases
    for (int m = 0; m < 2; m++) begin
      burst_ilv = m[0];
      cyc(0, 0, 0, 1, 10'd0, 3'b010, '1, '0, "R1 phase load");
      for (int k = 0; k < 3000; k++) begin
        logic ck, sl, al;
        logic [2:0] cs;
        ck = ($urandom % 10) == 0;
        sl = ($urandom % 20) == 0;
        al = ($urandom % 10) < 3;
        cs = (($urandom % 10) == 0) ? 3'($urandom % 8) : 3'b010;
        cyc(ck, sl, al, 1'($urandom), AW'($urandom % 64), cs, NB'($urandom),
            {4'($urandom), 32'($urandom)}, "R1/R2/R3/R7 random");
      end
    end

    done = 1;
    report();
  end
endmodule